// File: doc/BRIEF.md
# Serial Flash Page-Program Command Engine

This block is the slave-side command front end of a serial NOR flash, built small enough to live inside a larger chip. The chip select, serial clock and serial data input pins are brought into the system clock domain by synchronizers. The engine decodes a short set of instructions and returns read data on the serial output. Timing follows SPI mode 0: input bits are taken on the rising serial clock and output bits change on the falling serial clock, most significant bit first.

A program frame loads data bytes into a page buffer and wraps inside the page. When chip select rises cleanly, a self-timed program cycle copies the buffer into a small internal array one byte per system clock. Programming can only clear bits. A status byte reports the program cycle, the write-enable latch and the block-protect setting. The protect setting is a parameter, and it shields pages from the top of the array downward.

Top module: `spi_flash_pgm_engine`

## Requirements
- R1: The read-status opcode 05h returns the status byte and repeats it for every further byte of the frame. The byte holds busy in bit 0, the write-enable latch in bit 1 and the protect level `PROT_BP` in bits 4:2, with all other bits 0. After reset, busy and the latch are both 0.
- R2: The write-enable opcode 06h sets the write-enable latch.
- R3: The program opcode 02h is ignored when the write-enable latch is clear. The array stays unchanged and busy stays 0.
- R4: A program frame is the opcode, then three address bytes sent MSB first (only the low array-address bits are used), then one or more data bytes. Each data byte lands at the next column of the addressed page. All other bytes of the page keep their contents.
- R5: Data bytes beyond the end of the page wrap to column 0 of the same page. When a column is written more than once in a frame, the last byte written there is the one programmed.
- R6: The program runs only if chip select rises after a whole number of data bytes, with at least one data byte. Any other rise aborts the frame: the array, busy and the latch are left unchanged.
- R7: An accepted program sets busy for `PROG_CYCLES` system clocks and then clears it. The write-enable latch clears when the cycle starts.
- R8: The protected page count is 0 when `PROT_BP` is 0, the whole array when it is 7, and otherwise 2^(`PROT_BP`-1) top pages, capped at the page count. A program aimed at a protected page is not executed; busy and the latch are left unchanged.
- R9: Programming ANDs the buffered byte into the stored byte, so only 1-to-0 changes occur.
- R10: The read-identification opcode 9Fh returns 01h, then 02h, then 12h, then 00h for any further byte.
- R11: While busy, every opcode other than 05h is ignored. The output stays 0, and 06h does not set the latch.
- R12: The read opcode 03h plus three address bytes returns bytes from consecutive addresses, wrapping from the last array address to 0. After reset the whole array reads FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data into the engine |
| miso | output | 1 | Serial data out of the engine, 0 when deselected |

## Verification
The bench keeps the default four pages of 256 bytes, so a 260-byte frame shows the in-page wrap while a real page boundary sits next to it. It sets `PROT_BP` to 1, which protects only page 3 and leaves pages 0 to 2 writable, so refused and accepted programs can be compared in one run. `PROG_CYCLES` is 2000, long enough for several status and identification frames to fall inside one program cycle and show the busy-time lockout, yet short enough that the cycle ends within a few polls.

// File: rtl/spfe_pkg.sv
package spfe_pkg;
   localparam logic [7:0] OP_WREN = 8'h06;
   localparam logic [7:0] OP_PROG = 8'h02;
   localparam logic [7:0] OP_RDSR = 8'h05;
   localparam logic [7:0] OP_RDID = 8'h9F;
   localparam logic [7:0] OP_READ = 8'h03;

   localparam logic [7:0] ID_MFR  = 8'h01;
   localparam logic [7:0] ID_TYPE = 8'h02;
   localparam logic [7:0] ID_CAP  = 8'h12;

   typedef enum logic [2:0] {PH_OPC, PH_ADDR, PH_DATA, PH_OUT, PH_DROP} phase_t;
   typedef enum logic [1:0] {SRC_STAT, SRC_ID, SRC_MEM} src_t;
endpackage

// File: rtl/spfe_in_sync.sv
module spfe_in_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   if (STAGES < 1) begin : g_bad_stages
      $error("spfe_in_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] chain_q;

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= RST_VAL;
         else        chain_q <= din;
      end
   end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= {STAGES{RST_VAL}};
         else        chain_q <= {chain_q[STAGES-2:0], din};
      end
   end

   assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/spfe_page_buf.sv
module spfe_page_buf #(
   parameter int DEPTH = 256,
   parameter int COL_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fill,
   input  logic             wr_en,
   input  logic [COL_W-1:0] wr_col,
   input  logic [7:0]       wr_data,
   input  logic [COL_W-1:0] rd_col,
   output logic [7:0]       rd_data
);
   logic [7:0] slot_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) slot_q[i] <= 8'hFF;
      end else if (fill) begin
         for (int i = 0; i < DEPTH; i++) slot_q[i] <= 8'hFF;
      end else if (wr_en) begin
         slot_q[wr_col] <= wr_data;
      end
   end

   assign rd_data = slot_q[rd_col];
endmodule

// File: rtl/spfe_mem_array.sv
module spfe_mem_array #(
   parameter int WORDS = 1024,
   parameter int AW    = $clog2(WORDS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [7:0]    wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [7:0]    rd_data
);
   logic [7:0] cell_q [WORDS];
   logic [7:0] wr_old;

   assign wr_old  = cell_q[wr_addr];
   assign rd_data = cell_q[rd_addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < WORDS; i++) cell_q[i] <= 8'hFF;
      end else if (wr_en) begin
         cell_q[wr_addr] <= wr_old & wr_data;
      end
   end

   // R9
   and_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> cell_q[$past(wr_addr)] == ($past(wr_old) & $past(wr_data)));
endmodule

// File: rtl/spi_flash_pgm_engine.sv
module spi_flash_pgm_engine
   import spfe_pkg::*;
#(
   parameter int         NUM_PAGES   = 4,
   parameter int         PAGE_BYTES  = 256,
   parameter int         PROG_CYCLES = 4096,
   parameter logic [2:0] PROT_BP     = 3'd0,
   parameter int         SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sclk,
   input  logic mosi,
   output logic miso
);
   localparam int COL_W = $clog2(PAGE_BYTES);
   localparam int PG_W  = $clog2(NUM_PAGES);
   localparam int AW    = COL_W + PG_W;
   localparam int WORDS = NUM_PAGES * PAGE_BYTES;
   localparam int CNT_W = $clog2(PROG_CYCLES);
   localparam int BPV   = int'(PROT_BP);
   localparam int PROT_PAGES = (BPV == 0) ? 0 :
                               (BPV == 7) ? NUM_PAGES :
                               (((1 << (BPV - 1)) > NUM_PAGES) ? NUM_PAGES : (1 << (BPV - 1)));

   if (PAGE_BYTES < 2 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two, at least 2");
   end
   if (NUM_PAGES < 2 || (NUM_PAGES & (NUM_PAGES - 1)) != 0) begin : g_bad_pages
      $error("NUM_PAGES must be a power of two, at least 2");
   end
   if (PROG_CYCLES <= PAGE_BYTES) begin : g_bad_prog
      $error("PROG_CYCLES must exceed PAGE_BYTES");
   end

   // input synchronizers and edge detection
   logic cs_s, sclk_s, mosi_s, cs_d, sclk_d;
   spfe_in_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
      .clk(clk), .rst_n(rst_n), .din(cs_n), .dout(cs_s));
   spfe_in_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ck_sync (
      .clk(clk), .rst_n(rst_n), .din(sclk), .dout(sclk_s));
   spfe_in_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_di_sync (
      .clk(clk), .rst_n(rst_n), .din(mosi), .dout(mosi_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_d   <= 1'b1;
         sclk_d <= 1'b0;
      end else begin
         cs_d   <= cs_s;
         sclk_d <= sclk_s;
      end
   end

   logic cs_rise, sclk_rise, sclk_fall;
   assign cs_rise   = cs_s & ~cs_d;
   assign sclk_rise = sclk_s & ~sclk_d & ~cs_s;
   assign sclk_fall = ~sclk_s & sclk_d & ~cs_s;

   // frame state
   phase_t            phase_q;
   src_t              src_q;
   logic [7:0]        op_q, out_byte_q;
   logic [6:0]        sh_q;
   logic [2:0]        bit_q;
   logic [1:0]        byte_idx_q, id_idx_q;
   logic [AW-1:0]     addr_q;
   logic [COL_W-1:0]  col_q;
   logic [PG_W-1:0]   page_q, prog_page_q;
   logic [CNT_W-1:0]  prog_cnt_q;
   logic              data_seen_q, wel_q, busy_q, mem_load_q, miso_q;

   logic              byte_done, page_prot, buf_fill, buf_we, arr_we;
   logic [7:0]        rx_byte, status, buf_rd, arr_rd;
   logic [AW-1:0]     addr_nxt;

   assign byte_done = sclk_rise && (bit_q == 3'd7);
   assign rx_byte   = {sh_q, mosi_s};
   assign addr_nxt  = AW'({addr_q, rx_byte});
   assign status    = {3'b000, PROT_BP, wel_q, busy_q};
   assign page_prot = (32'(page_q) >= 32'(NUM_PAGES - PROT_PAGES));
   assign buf_fill  = byte_done && (phase_q == PH_OPC) && !busy_q && (rx_byte == OP_PROG) && wel_q;
   assign buf_we    = byte_done && (phase_q == PH_DATA);
   assign arr_we    = busy_q && (prog_cnt_q < CNT_W'(PAGE_BYTES));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q     <= PH_OPC;
         src_q       <= SRC_STAT;
         op_q        <= 8'h00;
         out_byte_q  <= 8'h00;
         sh_q        <= '0;
         bit_q       <= '0;
         byte_idx_q  <= '0;
         id_idx_q    <= '0;
         addr_q      <= '0;
         col_q       <= '0;
         page_q      <= '0;
         prog_page_q <= '0;
         prog_cnt_q  <= '0;
         data_seen_q <= 1'b0;
         wel_q       <= 1'b0;
         busy_q      <= 1'b0;
         mem_load_q  <= 1'b0;
         miso_q      <= 1'b0;
      end else begin
         mem_load_q <= 1'b0;
         // self-timed program cycle
         if (busy_q) begin
            prog_cnt_q <= prog_cnt_q + 1'b1;
            if (prog_cnt_q == CNT_W'(PROG_CYCLES - 1)) busy_q <= 1'b0;
         end
         if (mem_load_q) begin
            out_byte_q <= arr_rd;
            addr_q     <= addr_q + 1'b1;
         end
         if (cs_s) begin
            bit_q      <= '0;
            byte_idx_q <= '0;
            miso_q     <= 1'b0;
         end
         if (cs_rise) begin
            if (phase_q == PH_DATA && data_seen_q && bit_q == 3'd0 && !page_prot) begin
               busy_q      <= 1'b1;
               prog_cnt_q  <= '0;
               wel_q       <= 1'b0;
               prog_page_q <= page_q;
            end
            phase_q     <= PH_OPC;
            data_seen_q <= 1'b0;
         end
         if (sclk_rise) begin
            sh_q  <= rx_byte[6:0];
            bit_q <= bit_q + 1'b1;
         end
         if (sclk_fall) begin
            miso_q <= (phase_q == PH_OUT) ? out_byte_q[3'd7 - bit_q] : 1'b0;
         end
         if (byte_done) begin
            case (phase_q)
               PH_OPC: begin
                  op_q       <= rx_byte;
                  byte_idx_q <= '0;
                  phase_q    <= PH_DROP;
                  if (!busy_q || rx_byte == OP_RDSR) begin
                     case (rx_byte)
                        OP_WREN: wel_q <= 1'b1;
                        OP_PROG: if (wel_q) phase_q <= PH_ADDR;
                        OP_READ: phase_q <= PH_ADDR;
                        OP_RDSR: begin
                           phase_q    <= PH_OUT;
                           src_q      <= SRC_STAT;
                           out_byte_q <= status;
                        end
                        OP_RDID: begin
                           phase_q    <= PH_OUT;
                           src_q      <= SRC_ID;
                           out_byte_q <= ID_MFR;
                           id_idx_q   <= 2'd1;
                        end
                        default: ;
                     endcase
                  end
               end
               PH_ADDR: begin
                  addr_q     <= addr_nxt;
                  byte_idx_q <= byte_idx_q + 1'b1;
                  if (byte_idx_q == 2'd2) begin
                     if (op_q == OP_PROG) begin
                        phase_q <= PH_DATA;
                        col_q   <= addr_nxt[COL_W-1:0];
                        page_q  <= addr_nxt[AW-1:COL_W];
                     end else begin
                        phase_q    <= PH_OUT;
                        src_q      <= SRC_MEM;
                        mem_load_q <= 1'b1;
                     end
                  end
               end
               PH_DATA: begin
                  col_q       <= col_q + 1'b1;
                  data_seen_q <= 1'b1;
               end
               PH_OUT: begin
                  case (src_q)
                     SRC_STAT: out_byte_q <= status;
                     SRC_ID: begin
                        case (id_idx_q)
                           2'd1:    out_byte_q <= ID_TYPE;
                           2'd2:    out_byte_q <= ID_CAP;
                           default: out_byte_q <= 8'h00;
                        endcase
                        if (id_idx_q != 2'd3) id_idx_q <= id_idx_q + 1'b1;
                     end
                     default: mem_load_q <= 1'b1;
                  endcase
               end
               default: ;
            endcase
         end
      end
   end

   assign miso = miso_q & ~cs_s;

   spfe_page_buf #(.DEPTH(PAGE_BYTES), .COL_W(COL_W)) u_pbuf (
      .clk(clk), .rst_n(rst_n), .fill(buf_fill),
      .wr_en(buf_we), .wr_col(col_q), .wr_data(rx_byte),
      .rd_col(prog_cnt_q[COL_W-1:0]), .rd_data(buf_rd));

   spfe_mem_array #(.WORDS(WORDS), .AW(AW)) u_array (
      .clk(clk), .rst_n(rst_n), .wr_en(arr_we),
      .wr_addr({prog_page_q, prog_cnt_q[COL_W-1:0]}), .wr_data(buf_rd),
      .rd_addr(addr_q), .rd_data(arr_rd));

   // R7
   wel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> !wel_q);
   // R6
   start_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> $past(cs_rise));
   // R7
   prog_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> $past(prog_cnt_q) == CNT_W'(PROG_CYCLES - 1));
   // R11
   wel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wel_q) |-> !busy_q);
endmodule

// File: tb/spi_flash_pgm_engine_tb_top.sv
module spi_flash_pgm_engine_tb_top;
   localparam int  PB    = 256;
   localparam int  NP    = 4;
   localparam int  HALF  = 80;
   localparam logic [7:0] ST_BASE = 8'h04;   // PROT_BP = 1 in bits 4:2

   logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
   logic miso;
   int   n_chk = 0, n_fail = 0;
   bit   done = 1'b0;
   logic [7:0] exp_mem [NP*PB];
   logic [7:0] txq [300];

   always #5 clk = ~clk;

   spi_flash_pgm_engine #(.NUM_PAGES(NP), .PAGE_BYTES(PB), .PROG_CYCLES(2000),
                          .PROT_BP(3'd1), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso));

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic spi_bit(input logic b, output logic r);
      mosi = b;
      #HALF;
      r = miso;
      sclk = 1'b1;
      #HALF;
      sclk = 1'b0;
   endtask

   task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
      for (int i = 7; i >= 0; i--) spi_bit(tx[i], rx[i]);
   endtask

   task automatic sel();
      cs_n = 1'b0;
      #HALF;
   endtask

   task automatic desel();
      #HALF;
      cs_n = 1'b1;
      #(4*HALF);
   endtask

   task automatic send_addr(input logic [23:0] a);
      logic [7:0] d;
      spi_byte(a[23:16], d);
      spi_byte(a[15:8], d);
      spi_byte(a[7:0], d);
   endtask

   task automatic rd_status(output logic [7:0] s);
      logic [7:0] d;
      sel();
      spi_byte(8'h05, d);
      spi_byte(8'h00, s);
      desel();
   endtask

   task automatic wren();
      logic [7:0] d;
      sel();
      spi_byte(8'h06, d);
      desel();
   endtask

   // program frame: n whole data bytes from txq, then extra_bits loose bits
   task automatic pp(input logic [23:0] a, input int n, input int extra_bits);
      logic [7:0] d;
      logic r;
      sel();
      spi_byte(8'h02, d);
      send_addr(a);
      for (int k = 0; k < n; k++) spi_byte(txq[k], d);
      for (int k = 0; k < extra_bits; k++) spi_bit(1'b0, r);
      desel();
   endtask

   task automatic model_pp(input logic [23:0] a, input int n);
      logic [7:0] pbuf [PB];
      int pg;
      pg = int'(a[9:8]);
      for (int c = 0; c < PB; c++) pbuf[c] = 8'hFF;
      for (int k = 0; k < n; k++) pbuf[(int'(a[7:0]) + k) % PB] = txq[k];
      for (int c = 0; c < PB; c++) exp_mem[pg*PB + c] = exp_mem[pg*PB + c] & pbuf[c];
   endtask

   task automatic rd_cmp(input string req, input logic [23:0] a, input int n);
      logic [7:0] d;
      sel();
      spi_byte(8'h03, d);
      send_addr(a);
      for (int k = 0; k < n; k++) begin
         spi_byte(8'h00, d);
         check(req, d, exp_mem[(int'(a[9:0]) + k) % (NP*PB)]);
      end
      desel();
   endtask

   task automatic wait_idle(input string req);
      logic [7:0] s;
      int polls = 0;
      s = 8'h01;
      while (s[0] && polls < 40) begin
         rd_status(s);
         polls++;
      end
      check(req, {7'd0, s[0]}, 8'h00);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      sel();
      spi_byte(8'h05, d);
      spi_byte(8'h00, d);
      check("R1 status after reset", d, ST_BASE);
      spi_byte(8'h00, d);
      check("R1 status repeats", d, ST_BASE);
      desel();
      rd_cmp("R12 erased array", 24'h000000, 3);
   endtask

   task automatic t_rdid();
      logic [7:0] d;
      sel();
      spi_byte(8'h9F, d);
      spi_byte(8'h00, d); check("R10 id byte 0", d, 8'h01);
      spi_byte(8'h00, d); check("R10 id byte 1", d, 8'h02);
      spi_byte(8'h00, d); check("R10 id byte 2", d, 8'h12);
      spi_byte(8'h00, d); check("R10 id past end", d, 8'h00);
      desel();
   endtask

   task automatic t_no_wel();
      logic [7:0] s;
      txq[0] = 8'h00;
      pp(24'h000010, 1, 0);
      rd_status(s);
      check("R3 no program without latch", s, ST_BASE);
      rd_cmp("R3 array untouched", 24'h000010, 1);
   endtask

   task automatic t_small_and_busy();
      logic [7:0] s, d;
      wren();
      rd_status(s);
      check("R2 latch set", s, ST_BASE | 8'h02);
      txq[0] = 8'hA5; txq[1] = 8'h3C; txq[2] = 8'h0F;
      pp(24'h000005, 3, 0);
      model_pp(24'h000005, 3);
      rd_status(s);
      check("R7 busy set, latch cleared", s, ST_BASE | 8'h01);
      sel();
      spi_byte(8'h9F, d);
      spi_byte(8'h00, d);
      check("R11 id ignored while busy", d, 8'h00);
      desel();
      wren();
      wait_idle("R7 busy ends");
      rd_status(s);
      check("R11 latch not set while busy", s, ST_BASE);
      rd_cmp("R4 short program and neighbours", 24'h000004, 5);
   endtask

   task automatic t_and();
      wren();
      txq[0] = 8'hF0;
      pp(24'h000005, 1, 0);
      model_pp(24'h000005, 1);
      wait_idle("R9 cycle ends");
      rd_cmp("R9 only 1 to 0", 24'h000005, 1);
   endtask

   task automatic t_abort_prot();
      logic [7:0] s;
      wren();
      txq[0] = 8'h00;
      pp(24'h000100, 1, 3);
      rd_status(s);
      check("R6 mid-byte rise aborts", s, ST_BASE | 8'h02);
      pp(24'h000100, 0, 0);
      rd_status(s);
      check("R6 no data bytes aborts", s, ST_BASE | 8'h02);
      rd_cmp("R6 array untouched", 24'h000100, 1);
      pp(24'h000300, 1, 0);
      rd_status(s);
      check("R8 protected page refused", s, ST_BASE | 8'h02);
      rd_cmp("R8 protected page untouched", 24'h000300, 1);
   endtask

   task automatic t_wrap();
      for (int k = 0; k < 260; k++) txq[k] = 8'(k) ^ 8'h5A;
      wren();
      pp(24'h0002FE, 260, 0);
      model_pp(24'h0002FE, 260);
      wait_idle("R5 cycle ends");
      rd_cmp("R5 wrap tail columns", 24'h0002FE, 2);
      rd_cmp("R5 wrap head columns", 24'h000200, 4);
      rd_cmp("R5 neighbour page intact", 24'h0001FF, 1);
      rd_cmp("R12 read wraps at array end", 24'h0003FF, 2);
   endtask

   initial begin
      for (int i = 0; i < NP*PB; i++) exp_mem[i] = 8'hFF;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_rdid();
      t_no_wel();
      t_small_and_busy();
      t_and();
      t_abort_prot();
      t_wrap();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule